// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer

This block drives the complete chip-erase procedure of an on-chip flash array and its protection (lock) bits. A single `start` pulse launches it. First it preconditions the memory: each array byte, and then each lock bit, gets a fixed number of program pulses with no read-back between them. Next it fires one long erase pulse. It then erase-verifies the lock bits, and after that every array byte, checking each read-back byte against the erased pattern.

The sequencer generates no voltages and holds no memory. It drives a mode code, two supply-level requests, an address or index, and a strobe. The surrounding charge pumps and flash macro act on these. The macro returns read data on `rd_data`. Each supply change is followed by a settling wait before the next strobe. A failed verify stops the run at once. The result comes back as a single-cycle `done` with `fail` valid alongside it.

Top module: `flerase_seq`

## Requirements
- R1: After reset, and whenever idle, `busy`=0, `done`=0, `strobe`=0 and `mode_sel`=3'b000. The supply requests sit at nominal: `core_lvl`=1 and `pgm_lvl`=1.
- R2: A `start` seen while idle raises `busy` on the next cycle. A `start` while a run is in progress is ignored and changes no pulse count.
- R3: Preconditioning comes first. Every array address 0..2^ADDR_W-1 gets exactly PULSES strobes with `mode_sel`=3'b011. Then every lock index 0..LOCK_BITS-1 gets exactly PULSES strobes with `mode_sel`=3'b100. Each of these strobes lasts PROG_CYC cycles, and `rd_data` is not compared during them.
- R4: After preconditioning there is exactly one strobe with `mode_sel`=3'b010, lasting ERASE_CYC cycles.
- R5: Supply codes are: `core_lvl` 0=4.5 V, 1=5 V, 2=6.25 V; `pgm_lvl` 0=4.5 V, 1=5 V, 2=12.5 V. During program and erase strobes both codes are 2. During lock verify both are 0. During array verify `core_lvl`=0 and `pgm_lvl`=2.
- R6: After any change of `core_lvl` or `pgm_lvl`, `strobe` stays low for at least SETTLE_CYC cycles.
- R7: Lock verify (`mode_sel`=3'b101, one strobe per lock index) comes wholly before array verify (`mode_sel`=3'b001, one strobe per address). Each verify strobe lasts READ_CYC cycles, and `rd_data` is sampled in its last cycle. `addr` and `mode_sel` are stable while `strobe` is high.
- R8: A verify read passes only when `rd_data` equals ERASED_VAL (default 8'hFF). A byte with any single bit at 0 fails.
- R9: The first failing verify, lock or array, ends the run. No further strobes are issued, and `done` is reported with `fail`=1.
- R10: `done` is high for exactly one cycle with `busy`=0. `fail` is valid with it and holds until the next accepted `start`. The block then returns to idle.
- R11: Within each phase, `addr` walks upward from 0 (the lock index in lock phases, the byte address in array phases).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch the erase procedure (used only while idle) |
| rd_data | input | DATA_W | Read-back byte from the flash macro |
| busy | output | 1 | Procedure in progress |
| done | output | 1 | One-cycle completion flag |
| fail | output | 1 | Result: 1 = a verify failed |
| mode_sel | output | 3 | Operation code to the flash macro |
| core_lvl | output | 2 | Core supply level request |
| pgm_lvl | output | 2 | Programming supply level request |
| addr | output | ADDR_W | Byte address or lock-bit index |
| strobe | output | 1 | Operation strobe |

## Verification
The bench builds the block with ADDR_W=3, three lock bits, three pulses, PROG_CYC=2, ERASE_CYC=9, READ_CYC=2, SETTLE_CYC=4 and GAP_CYC=1. With these values a full run takes only a couple of hundred cycles. That makes it practical to count every strobe to every address, and to place a verify fault at the first and last lock index and at the first and last array byte. The short erase width still makes its length measurable, and the four-cycle settle is long enough to catch a strobe that arrives one cycle early.

// File: rtl/flerase_pkg.sv
package flerase_pkg;

   typedef enum logic [2:0] {
      MD_IDLE     = 3'b000,
      MD_VFY_ARR  = 3'b001,
      MD_ERASE    = 3'b010,
      MD_PRG_ARR  = 3'b011,
      MD_PRG_LOCK = 3'b100,
      MD_VFY_LOCK = 3'b101
   } mode_e;

   typedef enum logic [2:0] {
      PH_PRG_ARR,
      PH_PRG_LOCK,
      PH_ERASE,
      PH_VFY_LOCK,
      PH_VFY_ARR
   } phase_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_STROBE,
      ST_GAP,
      ST_REPORT
   } state_e;

   localparam logic [1:0] LVL_LOW  = 2'd0;
   localparam logic [1:0] LVL_NOM  = 2'd1;
   localparam logic [1:0] LVL_HIGH = 2'd2;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/flerase_timer.sv
module flerase_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/flerase_stepper.sv
module flerase_stepper
   import flerase_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int LOCK_BITS = 3,
   parameter int PULSES    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  phase_e            phase,
   output logic [ADDR_W-1:0] idx,
   output logic              walk_last
);
   localparam logic [ADDR_W-1:0] ARR_LAST  = '1;
   localparam logic [ADDR_W-1:0] LOCK_LAST = ADDR_W'(LOCK_BITS - 1);

   logic pulse_ph, arr_ph, idx_last, pulse_last;

   assign pulse_ph = (phase == PH_PRG_ARR) || (phase == PH_PRG_LOCK);
   assign arr_ph   = (phase == PH_PRG_ARR) || (phase == PH_VFY_ARR);
   assign idx_last = arr_ph ? (idx == ARR_LAST)
                            : ((phase == PH_ERASE) || (idx == LOCK_LAST));

   generate
      if (PULSES > 1) begin : g_multi_pulse
         localparam int PW = $clog2(PULSES);
         localparam logic [PW-1:0] P_LAST = PW'(PULSES - 1);
         logic [PW-1:0] pcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pcnt_q <= '0;
            else if (clr)              pcnt_q <= '0;
            else if (adv && pulse_ph)  pcnt_q <= pulse_last ? '0 : pcnt_q + 1'b1;
         end
         assign pulse_last = (pcnt_q == P_LAST);
      end else begin : g_single_pulse
         assign pulse_last = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   idx <= '0;
      else if (clr)                                 idx <= '0;
      else if (adv && (!pulse_ph || pulse_last))    idx <= idx + 1'b1;
   end

   assign walk_last = idx_last && (!pulse_ph || pulse_last);
endmodule

// File: rtl/flerase_fsm.sv
module flerase_fsm
   import flerase_pkg::*;
#(
   parameter int TW         = 8,
   parameter int PROG_CYC   = 4,
   parameter int ERASE_CYC  = 16,
   parameter int READ_CYC   = 2,
   parameter int SETTLE_CYC = 4,
   parameter int GAP_CYC    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          tmr_expired,
   input  logic          walk_last,
   input  logic          rd_ok,
   output state_e        state,
   output phase_e        phase,
   output logic          tmr_load,
   output logic [TW-1:0] tmr_val,
   output logic          step_clr,
   output logic          step_adv,
   output logic          fail_q
);
   localparam logic [TW-1:0] T_SET   = TW'(SETTLE_CYC - 1);
   localparam logic [TW-1:0] T_GAP   = TW'(GAP_CYC - 1);
   localparam logic [TW-1:0] T_PROG  = TW'(PROG_CYC - 1);
   localparam logic [TW-1:0] T_ERASE = TW'(ERASE_CYC - 1);
   localparam logic [TW-1:0] T_READ  = TW'(READ_CYC - 1);

   logic verify_ph;
   logic [TW-1:0] strobe_len;
   phase_e next_phase;

   assign verify_ph = (phase == PH_VFY_LOCK) || (phase == PH_VFY_ARR);

   always_comb begin
      unique case (phase)
         PH_ERASE:                strobe_len = T_ERASE;
         PH_VFY_LOCK, PH_VFY_ARR: strobe_len = T_READ;
         default:                 strobe_len = T_PROG;
      endcase
   end

   always_comb begin
      unique case (phase)
         PH_PRG_ARR:  next_phase = PH_PRG_LOCK;
         PH_PRG_LOCK: next_phase = PH_ERASE;
         PH_ERASE:    next_phase = PH_VFY_LOCK;
         default:     next_phase = PH_VFY_ARR;
      endcase
   end

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = T_SET;
      step_clr = 1'b0;
      step_adv = 1'b0;
      unique case (state)
         ST_IDLE: if (start) begin
            tmr_load = 1'b1;
            step_clr = 1'b1;
         end
         ST_SETTLE: if (tmr_expired) begin
            tmr_load = 1'b1;
            tmr_val  = strobe_len;
         end
         ST_STROBE: if (tmr_expired) begin
            tmr_load = 1'b1;
            tmr_val  = T_GAP;
         end
         ST_GAP: if (tmr_expired) begin
            tmr_load = 1'b1;
            if (!walk_last) begin
               step_adv = 1'b1;
               tmr_val  = strobe_len;
            end else begin
               step_clr = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         phase  <= PH_PRG_ARR;
         fail_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state  <= ST_SETTLE;
               phase  <= PH_PRG_ARR;
               fail_q <= 1'b0;
            end
            ST_SETTLE: if (tmr_expired) state <= ST_STROBE;
            ST_STROBE: if (tmr_expired) begin
               if (verify_ph && !rd_ok) begin
                  fail_q <= 1'b1;
                  state  <= ST_REPORT;
               end else begin
                  state  <= ST_GAP;
               end
            end
            ST_GAP: if (tmr_expired) begin
               if (!walk_last)              state <= ST_STROBE;
               else if (phase == PH_VFY_ARR) state <= ST_REPORT;
               else begin
                  phase <= next_phase;
                  state <= ST_SETTLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flerase_decode.sv
module flerase_decode
   import flerase_pkg::*;
(
   input  state_e      state,
   input  phase_e      phase,
   output logic        busy,
   output logic        done,
   output logic        strobe,
   output logic [2:0]  mode_sel,
   output logic [1:0]  core_lvl,
   output logic [1:0]  pgm_lvl
);
   mode_e md;

   assign busy   = (state == ST_SETTLE) || (state == ST_STROBE) || (state == ST_GAP);
   assign done   = (state == ST_REPORT);
   assign strobe = (state == ST_STROBE);

   always_comb begin
      md       = MD_IDLE;
      core_lvl = LVL_NOM;
      pgm_lvl  = LVL_NOM;
      if (busy) begin
         unique case (phase)
            PH_PRG_ARR:  begin md = MD_PRG_ARR;  core_lvl = LVL_HIGH; pgm_lvl = LVL_HIGH; end
            PH_PRG_LOCK: begin md = MD_PRG_LOCK; core_lvl = LVL_HIGH; pgm_lvl = LVL_HIGH; end
            PH_ERASE:    begin md = MD_ERASE;    core_lvl = LVL_HIGH; pgm_lvl = LVL_HIGH; end
            PH_VFY_LOCK: begin md = MD_VFY_LOCK; core_lvl = LVL_LOW;  pgm_lvl = LVL_LOW;  end
            default:     begin md = MD_VFY_ARR;  core_lvl = LVL_LOW;  pgm_lvl = LVL_HIGH; end
         endcase
      end
   end

   assign mode_sel = md;
endmodule

// File: rtl/flerase_seq.sv
module flerase_seq
   import flerase_pkg::*;
#(
   parameter int              ADDR_W     = 16,
   parameter int              DATA_W     = 8,
   parameter int              LOCK_BITS  = 3,
   parameter int              PULSES     = 3,
   parameter int              PROG_CYC   = 4000,
   parameter int              ERASE_CYC  = 20000000,
   parameter int              READ_CYC   = 4,
   parameter int              SETTLE_CYC = 400,
   parameter int              GAP_CYC    = 2,
   parameter logic [DATA_W-1:0] ERASED_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [2:0]        mode_sel,
   output logic [1:0]        core_lvl,
   output logic [1:0]        pgm_lvl,
   output logic [ADDR_W-1:0] addr,
   output logic              strobe
);
   localparam int MAXC = imax(imax(imax(PROG_CYC, ERASE_CYC), imax(READ_CYC, SETTLE_CYC)), GAP_CYC);
   localparam int TW   = $clog2(MAXC + 1);

   generate
      if (PULSES < 1 || PROG_CYC < 1 || ERASE_CYC < 1 || READ_CYC < 1 ||
          SETTLE_CYC < 1 || GAP_CYC < 1) begin : g_bad_timing
         $error("flerase_seq: pulse counts and cycle widths must be at least 1");
      end
      if (LOCK_BITS < 1 || LOCK_BITS > (1 << ADDR_W)) begin : g_bad_lock
         $error("flerase_seq: LOCK_BITS must lie in 1..2**ADDR_W");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("flerase_seq: ADDR_W and DATA_W must be at least 1");
      end
   endgenerate

   state_e        state;
   phase_e        phase;
   logic          tmr_load, tmr_expired, step_clr, step_adv, walk_last, rd_ok;
   logic [TW-1:0] tmr_val;

   assign rd_ok = (rd_data == ERASED_VAL);

   flerase_timer #(.TW(TW)) timer_i (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
   );

   flerase_stepper #(.ADDR_W(ADDR_W), .LOCK_BITS(LOCK_BITS), .PULSES(PULSES)) stepper_i (
      .clk(clk), .rst_n(rst_n), .clr(step_clr), .adv(step_adv), .phase(phase),
      .idx(addr), .walk_last(walk_last)
   );

   flerase_fsm #(
      .TW(TW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .READ_CYC(READ_CYC),
      .SETTLE_CYC(SETTLE_CYC), .GAP_CYC(GAP_CYC)
   ) fsm_i (
      .clk(clk), .rst_n(rst_n), .start(start), .tmr_expired(tmr_expired),
      .walk_last(walk_last), .rd_ok(rd_ok), .state(state), .phase(phase),
      .tmr_load(tmr_load), .tmr_val(tmr_val), .step_clr(step_clr),
      .step_adv(step_adv), .fail_q(fail)
   );

   flerase_decode decode_i (
      .state(state), .phase(phase), .busy(busy), .done(done), .strobe(strobe),
      .mode_sel(mode_sel), .core_lvl(core_lvl), .pgm_lvl(pgm_lvl)
   );
endmodule

// File: rtl/flerase_seq_chk.sv
module flerase_seq_chk #(
   parameter int ADDR_W     = 16,
   parameter int SETTLE_CYC = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [2:0]        mode_sel,
   input logic [1:0]        core_lvl,
   input logic [1:0]        pgm_lvl,
   input logic [ADDR_W-1:0] addr,
   input logic              strobe
);
   logic [1:0] core_prev, pgm_prev;
   int         quiet;
   logic       lvl_chg;

   assign lvl_chg = (core_lvl != core_prev) || (pgm_lvl != pgm_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_prev <= 2'd1;
         pgm_prev  <= 2'd1;
         quiet     <= 0;
      end else begin
         core_prev <= core_lvl;
         pgm_prev  <= pgm_lvl;
         if (lvl_chg)                 quiet <= 1;
         else if (quiet < SETTLE_CYC) quiet <= quiet + 1;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!strobe && mode_sel == 3'b000 && core_lvl == 2'd1 && pgm_lvl == 2'd1)); // R1
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done && start) |=> busy); // R2
   AST_PRG_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && (mode_sel == 3'b011 || mode_sel == 3'b100 || mode_sel == 3'b010))
         |-> (core_lvl == 2'd2 && pgm_lvl == 2'd2)); // R5
   AST_VLOCK_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && mode_sel == 3'b101) |-> (core_lvl == 2'd0 && pgm_lvl == 2'd0)); // R5
   AST_VARR_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && mode_sel == 3'b001) |-> (core_lvl == 2'd0 && pgm_lvl == 2'd2)); // R5
   AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (!lvl_chg && quiet >= SETTLE_CYC)); // R6
   AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && $past(strobe)) |-> ($stable(addr) && $stable(mode_sel))); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !strobe)); // R10
endmodule

bind flerase_seq flerase_seq_chk #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .mode_sel(mode_sel), .core_lvl(core_lvl), .pgm_lvl(pgm_lvl), .addr(addr),
   .strobe(strobe)
);

// File: tb/flerase_seq_tb.sv
module flerase_seq_tb_top;
   localparam int AW = 3, NARR = 1 << AW, NLOCK = 3, NPULSE = 3;
   localparam int PROGC = 2, ERASEC = 9, READC = 2, SETTLEC = 4, GAPC = 1;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [7:0] rd_data;
   logic busy, done, fail, strobe;
   logic [2:0] mode_sel;
   logic [1:0] core_lvl, pgm_lvl;
   logic [AW-1:0] addr;

   always #10 clk = ~clk;

   flerase_seq #(
      .ADDR_W(AW), .DATA_W(8), .LOCK_BITS(NLOCK), .PULSES(NPULSE), .PROG_CYC(PROGC),
      .ERASE_CYC(ERASEC), .READ_CYC(READC), .SETTLE_CYC(SETTLEC), .GAP_CYC(GAPC),
      .ERASED_VAL(8'hFF)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_data(rd_data), .busy(busy),
      .done(done), .fail(fail), .mode_sel(mode_sel), .core_lvl(core_lvl),
      .pgm_lvl(pgm_lvl), .addr(addr), .strobe(strobe)
   );

   // fault model: kind 0 none, 1 lock verify, 2 array verify
   int fkind = 0, fidx = 0;
   logic [7:0] fval = 8'h00;

   always_comb begin
      rd_data = 8'h00;                       // non-verify modes: zeros, never compared (R3)
      if (mode_sel == 3'b101)
         rd_data = (fkind == 1 && int'(addr) == fidx) ? fval : 8'hFF;
      else if (mode_sel == 3'b001)
         rd_data = (fkind == 2 && int'(addr) == fidx) ? fval : 8'hFF;
   end

   int n_chk = 0, n_fail = 0;
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int rank_of(input logic [2:0] m);
      case (m)
         3'b011: return 0;
         3'b100: return 1;
         3'b010: return 2;
         3'b101: return 3;
         3'b001: return 4;
         default: return 9;
      endcase
   endfunction
   function automatic logic [1:0] exp_core(input logic [2:0] m);
      return (m == 3'b101 || m == 3'b001) ? 2'd0 : 2'd2;
   endfunction
   function automatic logic [1:0] exp_pgm(input logic [2:0] m);
      return (m == 3'b101) ? 2'd0 : 2'd2;
   endfunction
   function automatic int exp_len(input logic [2:0] m);
      return (m == 3'b010) ? ERASEC : ((m == 3'b101 || m == 3'b001) ? READC : PROGC);
   endfunction

   // monitor
   int pre_cnt [NARR];
   int lock_cnt [NLOCK];
   int erase_cnt, erase_len, vl_cnt, va_cnt, sup_bad, settle_bad, order_bad, len_bad;
   int quiet, cur_len, last_rank, last_addr, glob_cyc;
   logic ps = 1'b0;
   logic [2:0] cur_mode;
   logic [1:0] pc = 2'd1, pp = 2'd1;

   task automatic clear_mon();
      foreach (pre_cnt[i]) pre_cnt[i] = 0;
      foreach (lock_cnt[i]) lock_cnt[i] = 0;
      erase_cnt = 0; erase_len = 0; vl_cnt = 0; va_cnt = 0; sup_bad = 0;
      settle_bad = 0; order_bad = 0; len_bad = 0; last_rank = 0; last_addr = -1;
   endtask

   always @(negedge clk) begin
      glob_cyc++;
      if (core_lvl != pc || pgm_lvl != pp) begin
         if (strobe) settle_bad++;
         quiet = 0;
      end else quiet++;
      pc = core_lvl; pp = pgm_lvl;
      if (strobe && !ps) begin
         if (quiet < SETTLE_CYC_chk()) settle_bad++;
         if (core_lvl != exp_core(mode_sel) || pgm_lvl != exp_pgm(mode_sel)) sup_bad++;
         if (rank_of(mode_sel) < last_rank || rank_of(mode_sel) == 9) order_bad++;
         if (rank_of(mode_sel) != last_rank) last_addr = -1;
         if (int'(addr) < last_addr) order_bad++;
         last_rank = rank_of(mode_sel); last_addr = int'(addr);
         case (mode_sel)
            3'b011: pre_cnt[addr]++;
            3'b100: if (int'(addr) < NLOCK) lock_cnt[addr]++; else order_bad++;
            3'b010: erase_cnt++;
            3'b101: vl_cnt++;
            3'b001: va_cnt++;
            default: order_bad++;
         endcase
         cur_mode = mode_sel; cur_len = 1;
      end else if (strobe && ps) cur_len++;
      else if (!strobe && ps) begin
         if (cur_len != exp_len(cur_mode)) len_bad++;
         if (cur_mode == 3'b010) erase_len = cur_len;
      end
      ps = strobe;
   end

   function automatic int SETTLE_CYC_chk();
      return SETTLE_CYC_val;
   endfunction
   localparam int SETTLE_CYC_val = SETTLEC;

   task automatic run_case(input int kind, input int idx, input logic [7:0] val, input bit poke);
      int cyc;
      logic fseen;
      int exp_vl, exp_va;
      fkind = kind; fidx = idx; fval = val;
      clear_mon();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      cyc = 0;
      while (!done && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         start = (poke && (cyc == 20 || cyc == 90)) ? 1'b1 : 1'b0;   // R2: ignored while busy
      end
      start = 1'b0;
      if (!done) begin
         chk(1'b0, "watchdog run hung", cyc, 0);
         return;
      end
      exp_vl = (kind == 1) ? idx + 1 : NLOCK;
      exp_va = (kind == 1) ? 0 : ((kind == 2) ? idx + 1 : NARR);
      for (int i = 0; i < NARR; i++) chk(pre_cnt[i] == NPULSE, "R3 array pulses", pre_cnt[i], NPULSE);
      for (int i = 0; i < NLOCK; i++) chk(lock_cnt[i] == NPULSE, "R3 lock pulses", lock_cnt[i], NPULSE);
      chk(erase_cnt == 1, "R4 erase count", erase_cnt, 1);
      chk(erase_len == ERASEC, "R4 erase width", erase_len, ERASEC);
      chk(len_bad == 0, "R3/R7 strobe widths", len_bad, 0);
      chk(sup_bad == 0, "R5 supply levels", sup_bad, 0);
      chk(settle_bad == 0, "R6 settle gap", settle_bad, 0);
      chk(order_bad == 0, "R7/R11 order", order_bad, 0);
      chk(vl_cnt == exp_vl, "R7/R9 lock verifies", vl_cnt, exp_vl);
      chk(va_cnt == exp_va, "R9 array verifies", va_cnt, exp_va);
      chk(fail == (kind != 0), "R8 result", fail, kind != 0);
      chk(!busy, "R10 not busy at done", busy, 0);
      fseen = fail;
      @(negedge clk);
      chk(!done && !busy, "R10 done single", done, 0);
      repeat (3) @(negedge clk);
      chk(fail == fseen && !strobe && mode_sel == 3'b000, "R10 fail held, idle", fail, fseen);
      chk(core_lvl == 2'd1 && pgm_lvl == 2'd1, "R1 idle supplies", core_lvl, 1);
   endtask

   always @(negedge clk) begin
      if (glob_cyc > 190000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog global actual=%0d expected=%0d", glob_cyc, 190000);
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int s, k, ix;
      logic [7:0] v;
      glob_cyc = 0; quiet = 0;
      clear_mon();
      s = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      chk(!busy && !done && !strobe && mode_sel == 3'b000, "R1 reset outputs", busy, 0);
      chk(core_lvl == 2'd1 && pgm_lvl == 2'd1, "R1 reset supplies", core_lvl, 1);
      rst_n = 1'b1;
      @(negedge clk);
      run_case(0, 0, 8'h00, 1'b0);            // clean pass R8
      run_case(0, 0, 8'h00, 1'b1);            // start while busy R2
      run_case(1, 0, 8'h00, 1'b0);            // first lock fails R9
      run_case(1, NLOCK - 1, 8'hFE, 1'b0);    // last lock, one bit low R8
      run_case(2, 0, 8'h7F, 1'b0);            // first byte, msb low R8
      run_case(2, NARR - 1, 8'hFE, 1'b1);     // last byte R9
      run_case(0, 0, 8'h00, 1'b0);            // pass after a fail clears result R10
      for (int r = 0; r < 14; r++) begin
         k  = int'($urandom % 3);
         ix = (k == 1) ? int'($urandom % NLOCK) : int'($urandom % NARR);
         v  = 8'($urandom);
         if (v == 8'hFF) v = 8'hBF;
         run_case(k, ix, v, 1'($urandom));
      end
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule